// File: doc/BRIEF.md
# PHY Management Command Unit

This block is a host-programmed controller for the management path of an Ethernet PHY, with a behavioural PHY register model attached. The host stores a command word that holds a PHY address, a register number and an operation code. When that word also has its initiate flag set, the unit either sends the write-data register to the addressed PHY register or fetches the addressed PHY register into the read-data register. The access completes within the cycle of the host write. One clock later the unit raises a single-cycle completion pulse.

The attached PHY answers only at the address set by a parameter. Reads at any other address return all ones in the low 16 bits. The model does not keep every register as plain storage. The basic status word depends on a link input. The link-partner word copies the advertised abilities. A diagnostic word derives speed and duplex from those abilities, and a vendor word is fixed. Every write to the PHY clears the soft-reset and restart-negotiation bits of the control word. There is no serial MDC/MDIO timing, so the command register always reads as ready.

Host register select codes: 0 = control, 1 = command, 2 = write data, 3 = read data.

Top module: `mgmt_cmd_unit`

## Requirements
- R1: After reset, PHY register 0 reads 0x3100, register 2 reads 0x0300, register 3 reads 0xE400 and register 4 reads 0x01E1. The completion pulse is low and the control register reads 0.
- R2: The command word holds the PHY address in bits 28:24, the register number in bits 20:16, the opcode in bits 15:14 and the initiate flag in bit 11. Bits 31:29 do not affect decoding. A command written without the initiate flag performs no access.
- R3: With initiate set, opcode 1 stores the low 16 bits of the write-data register into the addressed PHY register. Opcode 2 loads the addressed PHY register, zero-extended, into the read-data register on the clock edge that takes the command write.
- R4: With initiate set, opcodes 0 and 3 perform no access. The read-data register and the PHY registers are unchanged, and no completion pulse is raised.
- R5: A read at a PHY address other than the parameter PHY_ADDR (default 7) returns 0x0000FFFF. A write at such an address changes no PHY register.
- R6: The command register reads back the value last written with bit 7 forced to 1.
- R7: The control register keeps only bits 6:0 of a write: bit 6 is the enable and bits 5:0 are the clock divider. Bits 31:7 read as 0.
- R8: PHY register 1 reads 0x782E while the link input is high (bits 14, 13, 12, 11, 5, 3, 2 and 1 set) and 0 while it is low.
- R9: PHY register 5 reads 0x4000 OR (register 4 AND 0x01E0) OR 0x0001.
- R10: PHY register 18 sets bit 10 when register 4 bit 7 or bit 8 is set, and sets bit 11 when register 4 bit 8 or bit 6 is set. It reads 0 while the link is low. Register 17 always reads 0x8000.
- R11: Every PHY write stores its data and then clears bits 15 and 9 of register 0.
- R12: The completion pulse is high for exactly the one cycle after the edge that takes a valid initiated command (opcode 1 or 2), whether or not the address matches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| link_up | input | 1 | Link state reported by the PHY model |
| host_wr | input | 1 | Host register write strobe |
| host_sel | input | 2 | Register selected for the write |
| host_wdata | input | 32 | Host write data |
| host_rsel | input | 2 | Register selected for readback |
| host_rdata | output | 32 | Readback of the selected register |
| acc_done | output | 1 | Single-cycle access completion pulse |

## Verification
The bound checker applies its properties on every cycle. The ready bit and the zero upper bits of the control readback must always hold. The completion pulse must follow exactly the valid initiated commands. Invalid opcodes must never reach the PHY, a read at a missing address must always leave 0xFFFF, and control-word bits 15 and 9 must be clear after every PHY write. Only the bench's directed scenarios can show the derived PHY words: the link-status word, the mirrored partner abilities and the speed/duplex decode for different advertisement patterns. The bench also checks the reset contents, the stored write data, and that an ignored command leaves the PHY and the read-data register as they were.

// File: rtl/mgmt_pkg.sv
package mgmt_pkg;
  localparam int HOST_DW   = 32;
  localparam int PHY_DW    = 16;
  localparam int CTL_W     = 7;
  localparam int REG_N     = 32;
  localparam int REG_AW    = $clog2(REG_N);

  localparam logic [1:0] SEL_CTL  = 2'd0;
  localparam logic [1:0] SEL_CMD  = 2'd1;
  localparam logic [1:0] SEL_WDAT = 2'd2;
  localparam logic [1:0] SEL_RDAT = 2'd3;

  localparam logic [1:0] OP_WRITE = 2'd1;
  localparam logic [1:0] OP_READ  = 2'd2;

  localparam logic [PHY_DW-1:0] SCRUB_MASK = 16'h8200;
  localparam logic [PHY_DW-1:0] NO_DEVICE  = 16'hFFFF;

  typedef struct packed {
    logic [4:0] phy;
    logic [4:0] reg_n;
    logic [1:0] op;
    logic       go;
  } mgmt_cmd_t;

  function automatic mgmt_cmd_t decode_cmd(input logic [HOST_DW-1:0] w);
    mgmt_cmd_t c;
    c.phy   = w[28:24];
    c.reg_n = w[20:16];
    c.op    = w[15:14];
    c.go    = w[11];
    return c;
  endfunction

  function automatic logic [PHY_DW-1:0] reset_word(input int idx);
    case (idx)
      0:       return 16'h3100;
      2:       return 16'h0300;
      3:       return 16'hE400;
      4:       return 16'h01E1;
      default: return 16'h0000;
    endcase
  endfunction

  function automatic logic [PHY_DW-1:0] status_word(input logic link);
    return link ? 16'h782E : 16'h0000;
  endfunction

  function automatic logic [PHY_DW-1:0] partner_word(input logic [PHY_DW-1:0] adv);
    return 16'h4000 | (adv & 16'h01E0) | 16'h0001;
  endfunction

  function automatic logic [PHY_DW-1:0] diag_word(input logic link,
                                                  input logic [PHY_DW-1:0] adv);
    logic fast;
    logic full;
    fast = adv[7] | adv[8];
    full = adv[8] | adv[6];
    if (!link) return 16'h0000;
    return {4'b0, full, fast, 10'b0};
  endfunction
endpackage

// File: rtl/mgmt_phy_model.sv
module mgmt_phy_model
  import mgmt_pkg::*;
#(
  parameter int NREG = REG_N,
  parameter int DW   = PHY_DW,
  localparam int AW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          link_up,
  input  logic          wr_en,
  input  logic [AW-1:0] idx,
  input  logic [DW-1:0] wr_data,
  output logic [DW-1:0] rd_data,
  output logic [DW-1:0] ctrl_word
);
  logic [NREG*DW-1:0] flat;

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    logic [DW-1:0] q;
    if (i == 0) begin : g_ctrl
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
          q <= reset_word(i);
        else if (wr_en)
          q <= ((idx == AW'(0)) ? wr_data : q) & ~SCRUB_MASK;
      end
    end else begin : g_plain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
          q <= reset_word(i);
        else if (wr_en && idx == AW'(i))
          q <= wr_data;
      end
    end
    assign flat[i*DW +: DW] = q;
  end

  logic [DW-1:0] adv;
  assign adv       = flat[4*DW +: DW];
  assign ctrl_word = flat[0 +: DW];

  always_comb begin
    case (idx)
      AW'(1):  rd_data = status_word(link_up);
      AW'(5):  rd_data = partner_word(adv);
      AW'(17): rd_data = 16'h8000;
      AW'(18): rd_data = diag_word(link_up, adv);
      default: rd_data = flat[idx*DW +: DW];
    endcase
  end
endmodule

// File: rtl/mgmt_host_regs.sv
module mgmt_host_regs
  import mgmt_pkg::*;
#(
  parameter int PHY_ADDR = 7,
  parameter int DW       = HOST_DW,
  parameter int PDW      = PHY_DW,
  parameter int AW       = REG_AW
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           host_wr,
  input  logic [1:0]     host_sel,
  input  logic [DW-1:0]  host_wdata,
  input  logic [1:0]     host_rsel,
  output logic [DW-1:0]  host_rdata,
  output logic           acc_done,
  input  logic [PDW-1:0] phy_rdata,
  output logic           phy_wr_stb,
  output logic           phy_rd_stb,
  output logic           rd_req,
  output logic [AW-1:0]  phy_idx,
  output logic [PDW-1:0] phy_wdata,
  output logic [DW-1:0]  rdat_q
);
  logic [CTL_W-1:0] ctl_q;
  logic [DW-1:0]    cmd_q;
  logic [DW-1:0]    wdat_q;
  logic             done_q;

  mgmt_cmd_t cmd_now;
  logic      cmd_wr;
  logic      cmd_start;
  logic      wr_req;
  logic      addr_hit;

  assign cmd_now   = decode_cmd(host_wdata);
  assign cmd_wr    = host_wr && host_sel == SEL_CMD;
  assign cmd_start = cmd_wr && cmd_now.go &&
                     (cmd_now.op == OP_WRITE || cmd_now.op == OP_READ);
  assign wr_req    = cmd_start && cmd_now.op == OP_WRITE;
  assign rd_req    = cmd_start && cmd_now.op == OP_READ;
  assign addr_hit  = cmd_now.phy == 5'(PHY_ADDR);
  assign phy_wr_stb = wr_req && addr_hit;
  assign phy_rd_stb = rd_req && addr_hit;
  assign phy_idx   = AW'(cmd_now.reg_n);
  assign phy_wdata = wdat_q[PDW-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q  <= '0;
      cmd_q  <= '0;
      wdat_q <= '0;
      rdat_q <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= cmd_start;
      if (host_wr) begin
        case (host_sel)
          SEL_CTL:  ctl_q  <= host_wdata[CTL_W-1:0];
          SEL_CMD:  cmd_q  <= host_wdata;
          SEL_WDAT: wdat_q <= host_wdata;
          default:  rdat_q <= host_wdata;
        endcase
      end
      if (rd_req)
        rdat_q <= DW'(addr_hit ? phy_rdata : NO_DEVICE);
    end
  end

  assign acc_done = done_q;

  always_comb begin
    case (host_rsel)
      SEL_CTL:  host_rdata = DW'(ctl_q);
      SEL_CMD:  host_rdata = cmd_q | DW'(32'h80);
      SEL_WDAT: host_rdata = wdat_q;
      default:  host_rdata = rdat_q;
    endcase
  end
endmodule

// File: rtl/mgmt_cmd_unit.sv
module mgmt_cmd_unit
  import mgmt_pkg::*;
#(
  parameter int PHY_ADDR = 7
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        link_up,
  input  logic        host_wr,
  input  logic [1:0]  host_sel,
  input  logic [31:0] host_wdata,
  input  logic [1:0]  host_rsel,
  output logic [31:0] host_rdata,
  output logic        acc_done
);
  logic              phy_wr_stb;
  logic              phy_rd_stb;
  logic              rd_req;
  logic [REG_AW-1:0] phy_idx;
  logic [PHY_DW-1:0] phy_wdata;
  logic [PHY_DW-1:0] phy_rdata;
  logic [PHY_DW-1:0] phy_reg0;
  logic [31:0]       rdat_q;

  mgmt_host_regs #(.PHY_ADDR(PHY_ADDR)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .host_wr    (host_wr),
    .host_sel   (host_sel),
    .host_wdata (host_wdata),
    .host_rsel  (host_rsel),
    .host_rdata (host_rdata),
    .acc_done   (acc_done),
    .phy_rdata  (phy_rdata),
    .phy_wr_stb (phy_wr_stb),
    .phy_rd_stb (phy_rd_stb),
    .rd_req     (rd_req),
    .phy_idx    (phy_idx),
    .phy_wdata  (phy_wdata),
    .rdat_q     (rdat_q)
  );

  mgmt_phy_model u_phy (
    .clk       (clk),
    .rst_n     (rst_n),
    .link_up   (link_up),
    .wr_en     (phy_wr_stb),
    .idx       (phy_idx),
    .wr_data   (phy_wdata),
    .rd_data   (phy_rdata),
    .ctrl_word (phy_reg0)
  );
endmodule

// File: rtl/mgmt_cmd_unit_chk.sv
module mgmt_cmd_unit_chk #(
  parameter int PHY_ADDR = 7
) (
  input logic        clk,
  input logic        rst_n,
  input logic        host_wr,
  input logic [1:0]  host_sel,
  input logic [31:0] host_wdata,
  input logic [1:0]  host_rsel,
  input logic [31:0] host_rdata,
  input logic        acc_done,
  input logic        phy_wr_stb,
  input logic        phy_rd_stb,
  input logic [15:0] phy_reg0,
  input logic [31:0] rdat_q
);
  logic cmd_go;
  logic op_ok;
  assign cmd_go = host_wr && host_sel == 2'd1 && host_wdata[11];
  assign op_ok  = host_wdata[15:14] == 2'd1 || host_wdata[15:14] == 2'd2;

  AST_READY_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    host_rsel == 2'd1 |-> host_rdata[7]); // R6

  AST_CTL_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    host_rsel == 2'd0 |-> host_rdata[31:7] == 25'd0); // R7

  AST_DONE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_go && op_ok) |=> acc_done); // R12

  AST_DONE_ONLY_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd_go && op_ok) |=> !acc_done); // R4

  AST_BADOP_NO_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_go && !op_ok) |-> (!phy_wr_stb && !phy_rd_stb)); // R4

  AST_MISSING_DEVICE: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_go && host_wdata[15:14] == 2'd2 && host_wdata[28:24] != 5'(PHY_ADDR))
      |=> rdat_q == 32'h0000FFFF); // R5

  AST_SCRUB_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    phy_wr_stb |=> (!phy_reg0[15] && !phy_reg0[9])); // R11
endmodule

bind mgmt_cmd_unit mgmt_cmd_unit_chk #(.PHY_ADDR(PHY_ADDR)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .host_wr    (host_wr),
  .host_sel   (host_sel),
  .host_wdata (host_wdata),
  .host_rsel  (host_rsel),
  .host_rdata (host_rdata),
  .acc_done   (acc_done),
  .phy_wr_stb (phy_wr_stb),
  .phy_rd_stb (phy_rd_stb),
  .phy_reg0   (phy_reg0),
  .rdat_q     (rdat_q)
);

// File: tb/mgmt_cmd_unit_test.sv
`timescale 1ns/1ps
module mgmt_cmd_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        link_up = 1'b1;
  logic        host_wr = 1'b0;
  logic [1:0]  host_sel = 2'd0;
  logic [31:0] host_wdata = 32'd0;
  logic [1:0]  host_rsel = 2'd0;
  logic [31:0] host_rdata;
  logic        acc_done;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  mgmt_cmd_unit uut (
    .clk(clk), .rst_n(rst_n), .link_up(link_up), .host_wr(host_wr),
    .host_sel(host_sel), .host_wdata(host_wdata), .host_rsel(host_rsel),
    .host_rdata(host_rdata), .acc_done(acc_done)
  );

  always #10 clk = ~clk;

  function automatic logic [31:0] mk_cmd(input logic [4:0] pa, input logic [4:0] rn,
                                         input logic [1:0] op, input logic go);
    logic [31:0] w;
    w = 32'd0;
    w[28:24] = pa;
    w[20:16] = rn;
    w[15:14] = op;
    w[11]    = go;
    return w;
  endfunction

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, got, exp);
    end
  endtask

  task automatic host_write(input logic [1:0] sel, input logic [31:0] data);
    @(negedge clk);
    host_wr = 1'b1; host_sel = sel; host_wdata = data;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic peek(input logic [1:0] sel, output logic [31:0] v);
    host_rsel = sel;
    #1;
    v = host_rdata;
  endtask

  task automatic phy_read(input logic [4:0] pa, input logic [4:0] rn, output logic [31:0] v);
    host_write(2'd1, mk_cmd(pa, rn, 2'd2, 1'b1));
    peek(2'd3, v);
  endtask

  task automatic phy_write(input logic [4:0] pa, input logic [4:0] rn, input logic [15:0] d);
    host_write(2'd2, {16'h0, d});
    host_write(2'd1, mk_cmd(pa, rn, 2'd1, 1'b1));
  endtask

  task automatic t_reset;
    logic [31:0] v;
    check("R1 done low", {31'd0, acc_done}, 32'd0);
    peek(2'd0, v); check("R1 ctl reset", v, 32'd0);
    phy_read(5'd7, 5'd0, v); check("R1 reg0", v, 32'h3100);
    phy_read(5'd7, 5'd2, v); check("R1 reg2", v, 32'h0300);
    phy_read(5'd7, 5'd3, v); check("R1 reg3", v, 32'hE400);
    phy_read(5'd7, 5'd4, v); check("R1 reg4", v, 32'h01E1);
  endtask

  task automatic t_done;
    logic [31:0] v;
    host_write(2'd1, mk_cmd(5'd7, 5'd2, 2'd2, 1'b1));
    check("R12 done after edge", {31'd0, acc_done}, 32'd1);
    @(negedge clk);
    check("R12 done one cycle", {31'd0, acc_done}, 32'd0);
    host_write(2'd1, mk_cmd(5'd9, 5'd2, 2'd1, 1'b1));
    check("R12 done on missing addr", {31'd0, acc_done}, 32'd1);
    peek(2'd3, v); check("R3 read zero ext", v, 32'h0300);
  endtask

  task automatic t_status;
    logic [31:0] v;
    phy_read(5'd7, 5'd1, v); check("R8 link up", v, 32'h782E);
    phy_read(5'd7, 5'd17, v); check("R10 reg17", v, 32'h8000);
    phy_read(5'd7, 5'd18, v); check("R10 reg18 default", v, 32'h0C00);
    link_up = 1'b0;
    phy_read(5'd7, 5'd1, v); check("R8 link down", v, 32'h0);
    phy_read(5'd7, 5'd18, v); check("R10 reg18 link down", v, 32'h0);
    link_up = 1'b1;
  endtask

  task automatic t_mirror;
    logic [31:0] v;
    phy_read(5'd7, 5'd5, v); check("R9 reg5 default", v, 32'h41E1);
    phy_write(5'd7, 5'd4, 16'h0041);
    phy_read(5'd7, 5'd5, v); check("R9 reg5 10full", v, 32'h4041);
    phy_read(5'd7, 5'd18, v); check("R10 duplex only", v, 32'h0800);
    phy_write(5'd7, 5'd4, 16'h0080);
    phy_read(5'd7, 5'd5, v); check("R9 reg5 100half", v, 32'h4081);
    phy_read(5'd7, 5'd18, v); check("R10 speed only", v, 32'h0400);
    phy_write(5'd7, 5'd4, 16'h0100);
    phy_read(5'd7, 5'd18, v); check("R10 100full", v, 32'h0C00);
    phy_read(5'd7, 5'd5, v); check("R9 reg5 100full", v, 32'h4101);
  endtask

  task automatic t_write;
    logic [31:0] v;
    phy_write(5'd7, 5'd0, 16'hB300);
    phy_read(5'd7, 5'd0, v); check("R11 reg0 scrub", v, 32'h3100);
    phy_write(5'd7, 5'd10, 16'hABCD);
    phy_read(5'd7, 5'd10, v); check("R3 write stored", v, 32'hABCD);
    phy_read(5'd7, 5'd0, v); check("R11 reg0 after other write", v, 32'h3100);
    phy_write(5'd7, 5'd0, 16'h1200);
    phy_read(5'd7, 5'd0, v); check("R11 bit9 cleared", v, 32'h1000);
  endtask

  task automatic t_ignored;
    logic [31:0] v;
    host_write(2'd3, 32'h12345678);
    host_write(2'd2, 32'h00000000);
    host_write(2'd1, mk_cmd(5'd7, 5'd10, 2'd0, 1'b1));
    check("R4 op0 no done", {31'd0, acc_done}, 32'd0);
    host_write(2'd1, mk_cmd(5'd7, 5'd10, 2'd3, 1'b1));
    check("R4 op3 no done", {31'd0, acc_done}, 32'd0);
    peek(2'd3, v); check("R4 rdat kept", v, 32'h12345678);
    host_write(2'd1, mk_cmd(5'd7, 5'd10, 2'd1, 1'b0));
    check("R2 no initiate no done", {31'd0, acc_done}, 32'd0);
    host_write(2'd1, mk_cmd(5'd7, 5'd10, 2'd2, 1'b0));
    peek(2'd3, v); check("R2 no initiate rdat kept", v, 32'h12345678);
    phy_read(5'd7, 5'd10, v); check("R4 phy kept", v, 32'hABCD);
    host_write(2'd1, mk_cmd(5'd7, 5'd10, 2'd2, 1'b1) | 32'hE000_0000);
    peek(2'd3, v); check("R2 top bits ignored", v, 32'hABCD);
  endtask

  task automatic t_nophy;
    logic [31:0] v;
    phy_read(5'd3, 5'd10, v); check("R5 missing read", v, 32'h0000FFFF);
    phy_read(5'd6, 5'd0, v); check("R5 neighbour read", v, 32'h0000FFFF);
    phy_write(5'd3, 5'd10, 16'h1111);
    phy_read(5'd7, 5'd10, v); check("R5 missing write", v, 32'hABCD);
  endtask

  task automatic t_host_regs;
    logic [31:0] v;
    host_write(2'd0, 32'hFFFF_FFC5);
    peek(2'd0, v); check("R7 ctl mask", v, 32'h45);
    host_write(2'd1, 32'h00AB_0000);
    peek(2'd1, v); check("R6 ready readback", v, 32'h00AB_0080);
    host_write(2'd2, 32'hDEAD_BEEF);
    peek(2'd2, v); check("R3 wdat readback", v, 32'hDEAD_BEEF);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_done;
    t_status;
    t_mirror;
    t_write;
    t_ignored;
    t_nophy;
    t_host_regs;
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=hung expected=complete");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule